// File: doc/BRIEF.md
# Ring Waveform Capture Buffer with Region-of-Interest Readout

This block is the digital model of a circular sampling store and its readout sequencer. While it is running, one 12-bit sample per clock is written into a ring of cells, and old content is overwritten on every turn. The ring is built from equal banks, and a depth selector chains one, two, four or all banks into a single deeper ring. A trigger does not stop the ring at once. It loads a delay counter, and writing freezes only when that counter has run out. This lets the frozen window sit at a chosen place relative to a late trigger.

Once frozen, the sequencer reads back only a chosen number of consecutive cells. It starts at the cell where writing stopped, which holds the oldest sample, and wraps around the ring. Each sample that leaves the block has a per-cell offset subtracted. The offset is taken from a loadable table addressed by the physical cell number. The result is saturated to a signed 13-bit range and goes out as a valid-qualified stream, tagged with its cell index and with a last flag. Cells that were not written since the most recent arm read as zero, so content from an earlier acquisition cannot come back as a false pulse. A re-arm pulse, accepted only after readout has finished, restarts writing from the cell where it stopped.

Top module: `rwb_ring_capture`

## Requirements
- R1: While rst_n is low, wr_active is 1 and out_valid is 0. After reset the first sample is written to cell 0.
- R2: The ring depth is 64 << cfg_depth_sel cells (select 0..3 gives 64, 128, 256, 512; larger codes act as 3). While wr_active is high, one sample per cycle is written to the current cell, and the cell index then advances by one, wrapping from depth-1 to 0.
- R3: A trig seen while writing is running causes that cycle's sample plus exactly cfg_delay further samples to be written. On the next edge writing stops: wr_active falls, and stop_cell holds the cell that follows the last one written.
- R4: After the stop, out_valid is high for exactly N consecutive cycles, where N is cfg_roi sampled at the stop. out_cell steps from stop_cell upward, modulo the depth.
- R5: out_last is high together with the N-th output sample only. It is never high without out_valid.
- R6: out_data equals the stored sample minus the signed 14-bit table entry for out_cell. The entry is written through ped_we, ped_addr and ped_data.
- R7: The difference saturates to the range -4096..4095.
- R8: A cell not written since the latest reset or accepted re-arm reads as a raw value of 0.
- R9: trig is ignored during the delay countdown, during readout and after readout. The stop cell and the frozen state stay unchanged.
- R10: rearm is ignored until the last readout address has been issued. Once accepted, it raises wr_active on the next edge, and writing resumes at stop_cell. A trig in the same cycle as an accepted rearm is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | 12 | Unsigned sample written each active cycle |
| trig | input | 1 | Trigger, starts the stop delay |
| rearm | input | 1 | Restarts writing after readout |
| cfg_depth_sel | input | 2 | Ring depth select (number of chained banks) |
| cfg_delay | input | 16 | Samples written after the trigger sample |
| cfg_roi | input | 10 | Number of cells to read out |
| ped_we | input | 1 | Offset table write strobe |
| ped_addr | input | 9 | Offset table cell index |
| ped_data | input | 14 | Signed offset value |
| out_valid | output | 1 | Output sample qualifier |
| out_last | output | 1 | Final sample of the readout window |
| out_data | output | 13 | Signed corrected sample |
| out_cell | output | 9 | Physical cell of the output sample |
| stop_cell | output | 9 | Cell at which writing froze |
| wr_active | output | 1 | Ring is being written |

## Verification
Two functions can meet in one cycle: a trigger and an accepted re-arm, and a trigger or re-arm that arrives while the readout stream is being produced. The bench holds trig high through the whole readout, and it pulses rearm in the first readout cycle. It then shows that the block stays frozen, that stop_cell is unchanged, and that the stream keeps its length. It also drives trig in the same cycle as the accepted re-arm. Whether that trigger was ignored is decided by the stop cell of the next capture, which is computed from the trigger that follows it.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

  typedef enum logic [1:0] {
    ST_SAMPLE = 2'd0,
    ST_DELAY  = 2'd1,
    ST_READ   = 2'd2,
    ST_DONE   = 2'd3
  } rwb_state_e;

endpackage

// File: rtl/rwb_ring_store.sv
module rwb_ring_store #(
  parameter int BANK_CELLS = 64,
  parameter int BANK_CNT   = 8,
  parameter int SMP_W      = 12,
  localparam int TOTAL = BANK_CELLS * BANK_CNT,
  localparam int AW    = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [SMP_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [SMP_W-1:0] rd_data
);
  localparam int BW = $clog2(BANK_CELLS);
  localparam int SW = AW - BW;

  logic [TOTAL-1:0] wflag_q, wflag_d;
  logic             flag_rd_q;
  logic [SW-1:0]    bank_sel_q;
  logic [SMP_W-1:0] bank_rd [BANK_CNT];

  // written-since-arm marks: cleared as a whole on arm, set per write
  always_comb begin
    wflag_d = wflag_q;
    if (clr_all) wflag_d = '0;
    if (wr_en)   wflag_d[wr_addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wflag_q    <= '0;
      flag_rd_q  <= 1'b0;
      bank_sel_q <= '0;
    end else begin
      wflag_q <= wflag_d;
      if (rd_en) begin
        flag_rd_q  <= wflag_q[rd_addr];
        bank_sel_q <= rd_addr[AW-1:BW];
      end
    end
  end

  for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
    logic [SMP_W-1:0] mem [BANK_CELLS];
    logic [SMP_W-1:0] rd_q;
    logic             hit_w;

    assign hit_w = wr_en && (wr_addr[AW-1:BW] == SW'(b));

    always_ff @(posedge clk) begin
      if (hit_w) mem[wr_addr[BW-1:0]] <= wr_data;
      if (rd_en) rd_q <= mem[rd_addr[BW-1:0]];
    end

    assign bank_rd[b] = rd_q;
  end

  assign rd_data = flag_rd_q ? bank_rd[bank_sel_q] : '0;

endmodule

// File: rtl/rwb_ped_table.sv
module rwb_ped_table #(
  parameter int DEPTH = 512,
  parameter int PED_W = 14,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PED_W-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [PED_W-1:0] rdata
);
  logic [PED_W-1:0] mem [DEPTH];
  logic [PED_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rd_q <= mem[raddr];
  end

  assign rdata = rd_q;

endmodule

// File: rtl/rwb_seq_ctrl.sv
module rwb_seq_ctrl
  import rwb_pkg::*;
#(
  parameter int BANK_CELLS = 64,
  parameter int BANK_CNT   = 8,
  parameter int DLY_W      = 16,
  localparam int TOTAL     = BANK_CELLS * BANK_CNT,
  localparam int AW        = $clog2(TOTAL),
  localparam int CW        = AW + 1,
  localparam int LOG_BANKS = $clog2(BANK_CNT),
  localparam int SEL_W     = $clog2(LOG_BANKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             rearm,
  input  logic [SEL_W-1:0] cfg_depth_sel,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [CW-1:0]    cfg_roi,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic             clr_all,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             rd_last,
  output logic             wr_active,
  output logic [AW-1:0]    stop_cell
);
  rwb_state_e       state_q, state_d;
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [AW-1:0]    stop_q, stop_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [CW-1:0]    rd_cnt_q, rd_cnt_d;
  logic [CW-1:0]    roi_q, roi_d;
  logic [SEL_W-1:0] sel_eff;
  logic [CW-1:0]    depth;
  logic [CW:0]      cnt_nx;

  function automatic logic [AW-1:0] ring_step(input logic [AW-1:0] p,
                                              input logic [CW-1:0] d);
    logic [CW-1:0] s;
    s = {1'b0, p} + CW'(1);
    return (s >= d) ? '0 : s[AW-1:0];
  endfunction

  always_comb begin
    sel_eff = (int'(cfg_depth_sel) > LOG_BANKS) ? SEL_W'(LOG_BANKS) : cfg_depth_sel;
    depth   = CW'(BANK_CELLS) << sel_eff;
  end

  assign cnt_nx = {1'b0, rd_cnt_q} + (CW+1)'(1);

  always_comb begin
    state_d  = state_q;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    stop_d   = stop_q;
    dly_d    = dly_q;
    rd_cnt_d = rd_cnt_q;
    roi_d    = roi_q;
    wr_en    = 1'b0;
    clr_all  = 1'b0;
    rd_en    = 1'b0;
    rd_last  = 1'b0;
    unique case (state_q)
      ST_SAMPLE: begin
        wr_en    = 1'b1;
        wr_ptr_d = ring_step(wr_ptr_q, depth);
        if (trig) begin
          state_d = ST_DELAY;
          dly_d   = cfg_delay;
        end
      end
      ST_DELAY: begin
        if (dly_q == '0) begin
          state_d  = ST_READ;
          stop_d   = wr_ptr_q;
          rd_ptr_d = wr_ptr_q;
          rd_cnt_d = '0;
          roi_d    = cfg_roi;
        end else begin
          wr_en    = 1'b1;
          wr_ptr_d = ring_step(wr_ptr_q, depth);
          dly_d    = dly_q - DLY_W'(1);
        end
      end
      ST_READ: begin
        rd_en    = 1'b1;
        rd_last  = (cnt_nx >= {1'b0, roi_q});
        rd_ptr_d = ring_step(rd_ptr_q, depth);
        rd_cnt_d = cnt_nx[CW-1:0];
        if (rd_last) state_d = ST_DONE;
      end
      ST_DONE: begin
        if (rearm) begin
          state_d = ST_SAMPLE;
          clr_all = 1'b1;
        end
      end
      default: state_d = ST_SAMPLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_SAMPLE;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      stop_q   <= '0;
      dly_q    <= '0;
      rd_cnt_q <= '0;
      roi_q    <= '0;
    end else begin
      state_q  <= state_d;
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      stop_q   <= stop_d;
      dly_q    <= dly_d;
      rd_cnt_q <= rd_cnt_d;
      roi_q    <= roi_d;
    end
  end

  assign wr_addr   = wr_ptr_q;
  assign rd_addr   = rd_ptr_q;
  assign stop_cell = stop_q;
  assign wr_active = (state_q == ST_SAMPLE) || (state_q == ST_DELAY);

endmodule

// File: rtl/rwb_ped_correct.sv
module rwb_ped_correct #(
  parameter int SMP_W = 12,
  parameter int PED_W = 14,
  parameter int OUT_W = 13,
  parameter int AW    = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_last,
  input  logic [AW-1:0]           in_cell,
  input  logic [SMP_W-1:0]        raw,
  input  logic [PED_W-1:0]        ped,
  output logic                    out_valid,
  output logic                    out_last,
  output logic [AW-1:0]           out_cell,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int DW = ((PED_W > SMP_W) ? PED_W : SMP_W) + 2;
  localparam logic signed [DW-1:0] HI = DW'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [DW-1:0] LO = DW'(-(64'sd1 <<< (OUT_W-1)));

  logic signed [DW-1:0] raw_x, ped_x, diff, sat;

  always_comb begin
    raw_x = {{(DW-SMP_W){1'b0}}, raw};
    ped_x = {{(DW-PED_W){ped[PED_W-1]}}, ped};
    diff  = raw_x - ped_x;
    if (diff > HI)      sat = HI;
    else if (diff < LO) sat = LO;
    else                sat = diff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_cell  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_last  <= in_valid && in_last;
      if (in_valid) begin
        out_cell <= in_cell;
        out_data <= sat[OUT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/rwb_ring_capture.sv
module rwb_ring_capture #(
  parameter int BANK_CELLS = 64,
  parameter int BANK_CNT   = 8,
  parameter int SMP_W      = 12,
  parameter int PED_W      = 14,
  parameter int OUT_W      = 13,
  parameter int DLY_W      = 16,
  localparam int TOTAL     = BANK_CELLS * BANK_CNT,
  localparam int AW        = $clog2(TOTAL),
  localparam int CW        = AW + 1,
  localparam int SEL_W     = $clog2($clog2(BANK_CNT) + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SMP_W-1:0]        smp_in,
  input  logic                    trig,
  input  logic                    rearm,
  input  logic [SEL_W-1:0]        cfg_depth_sel,
  input  logic [DLY_W-1:0]        cfg_delay,
  input  logic [CW-1:0]           cfg_roi,
  input  logic                    ped_we,
  input  logic [AW-1:0]           ped_addr,
  input  logic signed [PED_W-1:0] ped_data,
  output logic                    out_valid,
  output logic                    out_last,
  output logic signed [OUT_W-1:0] out_data,
  output logic [AW-1:0]           out_cell,
  output logic [AW-1:0]           stop_cell,
  output logic                    wr_active
);
  logic             wr_en, clr_all, rd_en, rd_last;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [SMP_W-1:0] raw_rd;
  logic [PED_W-1:0] ped_rd;
  logic             v1_q, last1_q;
  logic [AW-1:0]    cell1_q;

  rwb_seq_ctrl #(
    .BANK_CELLS(BANK_CELLS), .BANK_CNT(BANK_CNT), .DLY_W(DLY_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .rearm(rearm),
    .cfg_depth_sel(cfg_depth_sel), .cfg_delay(cfg_delay), .cfg_roi(cfg_roi),
    .wr_en(wr_en), .wr_addr(wr_addr), .clr_all(clr_all),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_last(rd_last),
    .wr_active(wr_active), .stop_cell(stop_cell)
  );

  rwb_ring_store #(
    .BANK_CELLS(BANK_CELLS), .BANK_CNT(BANK_CNT), .SMP_W(SMP_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(smp_in),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(raw_rd)
  );

  rwb_ped_table #(
    .DEPTH(TOTAL), .PED_W(PED_W)
  ) u_ped (
    .clk(clk), .we(ped_we), .waddr(ped_addr), .wdata(ped_data),
    .re(rd_en), .raddr(rd_addr), .rdata(ped_rd)
  );

  // stage 1: qualifiers aligned with the registered memory reads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q    <= 1'b0;
      last1_q <= 1'b0;
      cell1_q <= '0;
    end else begin
      v1_q    <= rd_en;
      last1_q <= rd_en && rd_last;
      if (rd_en) cell1_q <= rd_addr;
    end
  end

  rwb_ped_correct #(
    .SMP_W(SMP_W), .PED_W(PED_W), .OUT_W(OUT_W), .AW(AW)
  ) u_corr (
    .clk(clk), .rst_n(rst_n),
    .in_valid(v1_q), .in_last(last1_q), .in_cell(cell1_q),
    .raw(raw_rd), .ped(ped_rd),
    .out_valid(out_valid), .out_last(out_last),
    .out_cell(out_cell), .out_data(out_data)
  );

endmodule

// File: rtl/rwb_ring_capture_chk.sv
module rwb_ring_capture_chk #(
  parameter int BANK_CELLS = 64,
  parameter int BANK_CNT   = 8,
  localparam int TOTAL     = BANK_CELLS * BANK_CNT,
  localparam int AW        = $clog2(TOTAL),
  localparam int LOG_BANKS = $clog2(BANK_CNT),
  localparam int SEL_W     = $clog2(LOG_BANKS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rearm,
  input logic [SEL_W-1:0] cfg_depth_sel,
  input logic             wr_active,
  input logic [AW-1:0]    stop_cell,
  input logic             out_valid,
  input logic             out_last,
  input logic [AW-1:0]    out_cell
);
  logic [AW-1:0]    prev_cell_q, exp_nx;
  logic             prev_v_q;
  logic [SEL_W-1:0] sel_eff;
  logic [AW:0]      dep, s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cell_q <= '0;
      prev_v_q    <= 1'b0;
    end else begin
      prev_cell_q <= out_cell;
      prev_v_q    <= out_valid;
    end
  end

  always_comb begin
    sel_eff = (int'(cfg_depth_sel) > LOG_BANKS) ? SEL_W'(LOG_BANKS) : cfg_depth_sel;
    dep     = (AW+1)'(BANK_CELLS) << sel_eff;
    s       = {1'b0, prev_cell_q} + (AW+1)'(1);
    exp_nx  = (s >= dep) ? '0 : s[AW-1:0];
  end

  // R4
  first_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_cell == stop_cell));

  // R4
  cell_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && prev_v_q) |-> (out_cell == exp_nx));

  // R4
  stream_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);

  // R5
  last_in_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R9
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_active && !rearm) |=> (!wr_active && $stable(stop_cell)));

  // R10
  resume_needs_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_active) |-> $past(rearm));

endmodule

bind rwb_ring_capture rwb_ring_capture_chk #(
  .BANK_CELLS(BANK_CELLS), .BANK_CNT(BANK_CNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rearm(rearm), .cfg_depth_sel(cfg_depth_sel),
  .wr_active(wr_active), .stop_cell(stop_cell),
  .out_valid(out_valid), .out_last(out_last), .out_cell(out_cell)
);

// File: tb/rwb_ring_capture_tb_top.sv
`timescale 1ns/1ps
module rwb_ring_capture_tb_top;
  localparam int CELLS = 512;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [11:0]       smp_in = '0;
  logic              trig = 1'b0;
  logic              rearm = 1'b0;
  logic [1:0]        cfg_depth_sel = 2'd3;
  logic [15:0]       cfg_delay = '0;
  logic [9:0]        cfg_roi = 10'd1;
  logic              ped_we = 1'b0;
  logic [8:0]        ped_addr = '0;
  logic signed [13:0] ped_data = '0;
  logic              out_valid, out_last, wr_active;
  logic signed [12:0] out_data;
  logic [8:0]        out_cell, stop_cell;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [11:0] m_mem [CELLS];
  bit          m_flag [CELLS];
  int          m_ped [CELLS];
  int          m_ptr = 0;
  int          m_depth = 512;
  bit          m_wr = 1'b0;
  bit          pw = 1'b0;
  int          pa = 0;
  int          pd = 0;

  always #4 clk = ~clk;

  rwb_ring_capture dut_i (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .trig(trig), .rearm(rearm),
    .cfg_depth_sel(cfg_depth_sel), .cfg_delay(cfg_delay), .cfg_roi(cfg_roi),
    .ped_we(ped_we), .ped_addr(ped_addr), .ped_data(ped_data),
    .out_valid(out_valid), .out_last(out_last), .out_data(out_data),
    .out_cell(out_cell), .stop_cell(stop_cell), .wr_active(wr_active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_out(input int c);
    int raw, d;
    raw = m_flag[c] ? int'(m_mem[c]) : 0;
    d = raw - m_ped[c];
    if (d > 4095) d = 4095;
    if (d < -4096) d = -4096;
    return d;
  endfunction

  function automatic logic [11:0] rnd();
    return 12'($urandom_range(4095));
  endfunction

  // one cycle of stimulus; the model write belongs to the following edge
  task automatic tick(input logic [11:0] s, input bit t, input bit ra);
    @(negedge clk);
    smp_in = s; trig = t; rearm = ra;
    ped_we = pw; ped_addr = 9'(pa); ped_data = 14'(pd);
    if (m_wr) begin
      m_mem[m_ptr] = s;
      m_flag[m_ptr] = 1'b1;
      m_ptr = (m_ptr + 1) % m_depth;
    end
    if (pw) m_ped[pa] = pd;
  endtask

  task automatic do_reset(input int sel);
    @(negedge clk);
    rst_n = 1'b0; trig = 1'b0; rearm = 1'b0; cfg_depth_sel = 2'(sel);
    repeat (2) @(negedge clk);
    chk(wr_active == 1'b1, "R1 wr_active in reset", int'(wr_active), 1);
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    m_depth = 64 << sel;
    m_ptr = 0;
    for (int i = 0; i < CELLS; i++) m_flag[i] = 1'b0;
    m_wr = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    smp_in = rnd();
    m_mem[m_ptr] = smp_in; m_flag[m_ptr] = 1'b1;
    m_ptr = (m_ptr + 1) % m_depth;
  endtask

  task automatic load_peds();
    for (int c = 0; c < CELLS; c++) begin
      pw = 1'b1; pa = c;
      if (c % 37 == 5)      pd = -8192;
      else if (c % 41 == 7) pd = 8191;
      else                  pd = int'($urandom_range(600)) - 300;
      tick(rnd(), 1'b0, 1'b0);
    end
    pw = 1'b0;
    tick(rnd(), 1'b0, 1'b0);
  endtask

  // poke: hold trig through delay and readout, pulse rearm early in readout
  task automatic capture(input int pre, input int dly, input int roi, input bit poke);
    int exp_stop, w, c;
    cfg_delay = 16'(dly);
    cfg_roi = 10'(roi);
    for (int i = 0; i < pre; i++) tick(rnd(), 1'b0, 1'b0);
    tick(rnd(), 1'b1, 1'b0);
    for (int d = 0; d < dly; d++) tick(rnd(), poke, 1'b0);
    m_wr = 1'b0;
    tick(rnd(), poke, 1'b0);
    exp_stop = m_ptr;
    @(negedge clk);
    chk(wr_active == 1'b0, "R3 frozen after delay", int'(wr_active), 0);
    chk(int'(stop_cell) == exp_stop, "R3 stop cell", int'(stop_cell), exp_stop);
    rearm = poke;               // R10: ignored while reading
    w = 0;
    while (!out_valid && w < 20) begin
      @(negedge clk);
      rearm = 1'b0;
      w++;
    end
    chk(out_valid == 1'b1, "R4 stream start", int'(out_valid), 1);
    for (int k = 0; k < roi; k++) begin
      c = (exp_stop + k) % m_depth;
      chk(out_valid == 1'b1, "R4 valid length", int'(out_valid), 1);
      chk(int'(out_cell) == c, "R4 cell order", int'(out_cell), c);
      chk(int'(out_data) == exp_out(c), "R6/R7/R8 corrected data", int'(out_data), exp_out(c));
      chk(out_last == (k == roi - 1), "R5 last flag", int'(out_last), int'(k == roi - 1));
      @(negedge clk);
    end
    chk(out_valid == 1'b0, "R4 stream end", int'(out_valid), 0);
    chk(wr_active == 1'b0, "R9 trig ignored when frozen", int'(wr_active), 0);
    chk(int'(stop_cell) == exp_stop, "R9 stop cell held", int'(stop_cell), exp_stop);
    trig = 1'b0;
  endtask

  task automatic rearm_ring(input bit with_trig);
    m_wr = 1'b0;
    tick(rnd(), with_trig, 1'b1);
    for (int i = 0; i < CELLS; i++) m_flag[i] = 1'b0;
    m_wr = 1'b1;
    tick(rnd(), 1'b0, 1'b0);
    chk(wr_active == 1'b1, "R10 writing resumed", int'(wr_active), 1);
  endtask

  initial begin
    int sel;
    void'($urandom(32'd20240611));
    do_reset(3);
    load_peds();                       // R2: wraps the 512-cell ring once
    capture(20, 5, 100, 1'b1);
    rearm_ring(1'b0);
    capture(0, 0, 40, 1'b0);           // R8: almost all cells stale
    rearm_ring(1'b1);                  // R10: trig with rearm ignored
    capture(3, 300, 64, 1'b1);
    rearm_ring(1'b0);
    capture(5, 2, 1, 1'b0);            // R5: single-sample window
    do_reset(0);                       // R1: first write lands in cell 0
    capture(100, 10, 64, 1'b1);        // R2: full 64-cell ring with wrap
    rearm_ring(1'b0);
    for (int s = 0; s < 4; s++) begin
      sel = s;
      do_reset(sel);
      for (int r = 0; r < 3; r++) begin
        capture(int'($urandom_range(300)), int'($urandom_range(200)),
                1 + int'($urandom_range((64 << sel) - 1)), 1'($urandom_range(1)));
        rearm_ring(1'($urandom_range(1)));
      end
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule